// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter. Software writes a start request. The block then opens the sample switch and waits a short start delay. After that it steps a trial code through the external DAC, most significant bit first. At each step it keeps or drops the trial bit according to the comparator. A ninth conversion-clock slot acts as a settle and transfer slot. At the end of that slot the final code moves into the result register, the busy status drops, the completion flag rises and sampling resumes, all on the same clock edge.

The conversion clock is derived in one of two ways. The first is a power-of-two division of the system clock, selected by a two-bit field. The second is a free-running internal RC clock, modelled here as a fixed number of system clocks. The RC source adds one extra instruction cycle to the start delay. The clock-source and divider selections are captured when a conversion is accepted. Software can abort a running conversion by clearing the request, and it clears the completion flag with a separate pulse.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy is 0, sample_en is 1, flag is 0 and result is 0.
- R2: A go_set pulse while idle, with go_clr low, makes busy 1 and sample_en 0 from the next clock. sample_en stays 0 for as long as busy is 1.
- R3: The first trial code 0x80 is on dac_code D clocks after the accepting edge. D is 1 when clk_sel=0 (system-derived clock) and 1+INSTR_CLKS when clk_sel=1 (RC clock).
- R4: Each conversion-clock slot lasts L system clocks. With clk_sel=0, L is 2^(1+2*div_sel), giving 2, 8, 32 or 128 for div_sel 0 to 3. With clk_sel=1, L is RC_DIV.
- R5: During slot p (p = 0 to 7), dac_code holds the bits already decided above bit 7-p, a 1 at bit 7-p, and zeros below it. cmp_in = 1 means the input is at or above the trial code. cmp_in is sampled on the last clock of the slot, and a 1 keeps the bit.
- R6: A conversion has nine slots. During slot 8, dac_code equals the final code. Completion falls D+9L clocks after the accepting edge.
- R7: result holds its old value during a conversion. It takes the final code on the completion edge, on the same edge where busy falls, flag rises and sample_en returns to 1.
- R8: flag stays at 1 until a flag_clr pulse. A completion in the same cycle as flag_clr leaves flag at 1.
- R9: go_set while busy is ignored. The running conversion keeps its timing and its result.
- R10: go_clr while busy aborts the conversion. From the next clock the block is idle, and result and flag are unchanged. The abort wins over a completion in the same cycle. go_set together with go_clr while idle starts nothing.
- R11: clk_sel and div_sel are captured at acceptance. Changing them during a conversion does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_set | input | 1 | Start request pulse (software writes the start bit) |
| go_clr | input | 1 | Abort pulse (software clears the start bit) |
| clk_sel | input | 1 | Conversion clock source: 0 system-derived, 1 RC |
| div_sel | input | 2 | System-clock divider select |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |
| flag_clr | input | 1 | Clear pulse for the completion flag |
| sample_en | output | 1 | Sample switch closed (1) or open (0) |
| dac_code | output | NBITS | Trial code to the DAC |
| result | output | NBITS | Result register |
| busy | output | 1 | Conversion in progress (start bit status) |
| flag | output | 1 | Completion flag |

## Verification
The hardest cases to reach are the ones that share a clock with the completion edge: an abort or a flag clear on the very cycle in which the final code would be transferred. The bench runs a behavioural model that counts the clocks elapsed since acceptance. It uses that count to place go_clr or flag_clr exactly one edge before the predicted completion. A changing analog value is modelled as a comparator fed from a held input byte, so every code path from 0x00 to 0xFF can be steered. Divider changes and stray start pulses in mid-conversion show that the captured settings hold.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_CONV  = 2'd2
  } sar_state_e;

  localparam int unsigned DIV_W = 2;
endpackage

// File: rtl/sar_seq_timebase.sv
module sar_seq_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS      = 8,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SLOT_W     = 4,
  parameter int unsigned INSTR_CLKS = 4,
  parameter int unsigned RC_DIV     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_set,
  input  logic              go_clr,
  input  logic              clk_sel,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              expired,
  output sar_state_e        state,
  output logic [SLOT_W-1:0] slot,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              start_conv,
  output logic              tick,
  output logic              done
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NBITS);
  localparam logic [CNT_W-1:0]  DLY_RC_M1 = CNT_W'(INSTR_CLKS);
  localparam logic [CNT_W-1:0]  RC_M1     = CNT_W'(RC_DIV - 1);

  sar_state_e        st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              rc_q, rc_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  period_m1;

  always_comb begin
    if (rc_q) begin
      period_m1 = RC_M1;
    end else begin
      period_m1 = (CNT_W'(2) << {div_q, 1'b0}) - CNT_W'(1);
    end
  end

  always_comb begin
    st_d       = st_q;
    slot_d     = slot_q;
    rc_d       = rc_q;
    div_d      = div_q;
    load       = 1'b0;
    load_val   = '0;
    start_conv = 1'b0;
    tick       = 1'b0;
    done       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_set && !go_clr) begin
          st_d     = ST_DELAY;
          rc_d     = clk_sel;
          div_d    = div_sel;
          load     = 1'b1;
          load_val = clk_sel ? DLY_RC_M1 : '0;
        end
      end
      ST_DELAY: begin
        if (go_clr) begin
          st_d = ST_IDLE;
        end else if (expired) begin
          st_d       = ST_CONV;
          slot_d     = '0;
          load       = 1'b1;
          load_val   = period_m1;
          start_conv = 1'b1;
        end
      end
      ST_CONV: begin
        if (go_clr) begin
          st_d = ST_IDLE;
        end else if (expired) begin
          load     = 1'b1;
          load_val = period_m1;
          if (slot_q == LAST_SLOT) begin
            done = 1'b1;
            st_d = ST_IDLE;
          end else begin
            tick   = 1'b1;
            slot_d = slot_q + SLOT_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      rc_q   <= 1'b0;
      div_q  <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      rc_q   <= rc_d;
      div_q  <= div_d;
    end
  end

  assign state = st_q;
  assign slot  = slot_q;
endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int unsigned NBITS  = 8,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_conv,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              cmp_in,
  output logic [NBITS-1:0]  code
);
  logic [NBITS-1:0] code_q, code_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    localparam int unsigned K = NBITS - 1 - i;
    logic nb;
    always_comb begin
      nb = code_q[i];
      if (start_conv) begin
        nb = (i == NBITS - 1) ? 1'b1 : 1'b0;
      end else if (tick && slot == SLOT_W'(K)) begin
        nb = cmp_in;
      end else if (tick && (slot + SLOT_W'(1)) == SLOT_W'(K)) begin
        nb = 1'b1;
      end
    end
    assign code_d[i] = nb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (start_conv || tick) begin
      code_q <= code_d;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             flag_clr,
  input  logic [NBITS-1:0] code,
  output logic [NBITS-1:0] result,
  output logic             flag
);
  logic [NBITS-1:0] res_q;
  logic             flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (done) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (done) begin
      res_q <= code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign result = res_q;
  assign flag   = flag_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS      = 8,
  parameter int unsigned INSTR_CLKS = 4,
  parameter int unsigned RC_DIV     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic             clk_sel,
  input  logic [1:0]       div_sel,
  input  logic             cmp_in,
  input  logic             flag_clr,
  output logic             sample_en,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result,
  output logic             busy,
  output logic             flag
);
  localparam int unsigned SYS_MAX = 2 << (2 * ((1 << DIV_W) - 1));
  localparam int unsigned MAX_A   = (SYS_MAX > RC_DIV) ? SYS_MAX : RC_DIV;
  localparam int unsigned MAX_LEN = (MAX_A > INSTR_CLKS + 1) ? MAX_A : INSTR_CLKS + 1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned SLOT_W  = $clog2(NBITS + 1);

  sar_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic              load, expired, start_conv, tick, done;
  logic [CNT_W-1:0]  load_val;

  sar_seq_fsm #(
    .NBITS(NBITS), .CNT_W(CNT_W), .SLOT_W(SLOT_W),
    .INSTR_CLKS(INSTR_CLKS), .RC_DIV(RC_DIV)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .go_clr(go_clr),
    .clk_sel(clk_sel), .div_sel(div_sel), .expired(expired),
    .state(state), .slot(slot), .load(load), .load_val(load_val),
    .start_conv(start_conv), .tick(tick), .done(done)
  );

  sar_seq_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .expired(expired)
  );

  sar_seq_sar #(.NBITS(NBITS), .SLOT_W(SLOT_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .tick(tick),
    .slot(slot), .cmp_in(cmp_in), .code(dac_code)
  );

  sar_seq_out #(.NBITS(NBITS)) u_out (
    .clk(clk), .rst_n(rst_n), .done(done), .flag_clr(flag_clr),
    .code(dac_code), .result(result), .flag(flag)
  );

  assign busy      = (state != ST_IDLE);
  assign sample_en = (state == ST_IDLE);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_set,
  input logic             go_clr,
  input logic             flag_clr,
  input logic             sample_en,
  input logic [NBITS-1:0] result,
  input logic             busy,
  input logic             flag
);
  p_go_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go_set && !go_clr) |=> (busy && !sample_en));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  p_flag_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($fell(busy) && $rose(sample_en)));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_clr && !flag_clr) |=> (!busy && $stable(result) && $stable(flag)));

  p_idle_nostart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go_clr) |=> !busy);
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_set(go_set), .go_clr(go_clr),
  .flag_clr(flag_clr), .sample_en(sample_en), .result(result),
  .busy(busy), .flag(flag)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int INSTR_CLKS = 4;
  localparam int RC_DIV     = 6;

  logic       clk, rst_n, go_set, go_clr, clk_sel, cmp_in, flag_clr;
  logic [1:0] div_sel;
  logic       sample_en, busy, flag;
  logic [7:0] dac_code, result;
  logic [7:0] vin;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference state
  bit m_busy, m_flag;
  int m_e, m_d, m_l;
  logic [7:0] m_res;

  sar_seq #(.NBITS(8), .INSTR_CLKS(INSTR_CLKS), .RC_DIV(RC_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .go_clr(go_clr),
    .clk_sel(clk_sel), .div_sel(div_sel), .cmp_in(cmp_in),
    .flag_clr(flag_clr), .sample_en(sample_en), .dac_code(dac_code),
    .result(result), .busy(busy), .flag(flag)
  );

  assign cmp_in = (vin >= dac_code);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endfunction

  // reference model: advances on each edge from the inputs it sees
  always @(posedge clk) begin
    bit fin;
    cycles++;
    fin = 0;
    if (!rst_n) begin
      m_busy = 0; m_flag = 0; m_e = 0; m_res = 8'h00; m_d = 1; m_l = 2;
    end else begin
      if (m_busy) begin
        if (go_clr) m_busy = 0;
        else begin
          m_e++;
          if (m_e == m_d + 9 * m_l) begin
            m_busy = 0; m_res = vin; fin = 1;
          end
        end
      end else if (go_set && !go_clr) begin
        m_busy = 1; m_e = 0;
        m_d = clk_sel ? 1 + INSTR_CLKS : 1;
        m_l = clk_sel ? RC_DIV : (2 << (2 * div_sel));
      end
      if (fin) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cycles > 1) begin
      int p;
      logic [7:0] exp_dac;
      chk("R2 busy", busy, m_busy);
      chk("R2 sample_en", sample_en, !m_busy);
      chk("R8 flag", flag, m_flag);
      chk("R7 result", result, m_res);
      if (m_busy && m_e >= m_d) begin
        p = (m_e - m_d) / m_l;
        if (p < 8) exp_dac = (vin & ~((8'h01 << (8 - p)) - 8'h01)) | (8'h80 >> p);
        else exp_dac = vin;
        if (p == 0 && m_e == m_d) chk("R3 first trial", dac_code, exp_dac);
        else if (p == 8) chk("R6 settle slot code", dac_code, exp_dac);
        else if ((m_e - m_d) % m_l == 0) chk("R4 slot boundary code", dac_code, exp_dac);
        else chk("R5 trial code", dac_code, exp_dac);
      end
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic go(input logic [7:0] v, input logic sel, input logic [1:0] dv);
    @(negedge clk);
    vin = v; clk_sel = sel; div_sel = dv; go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  // place a pulse so it is seen on the predicted completion edge
  task automatic wait_last_edge();
    while (!(m_busy && m_e == m_d + 9 * m_l - 1)) @(negedge clk);
  endtask

  initial begin
    int n;
    logic [7:0] old;
    rst_n = 1'b0; go_set = 0; go_clr = 0; clk_sel = 0; div_sel = 0;
    flag_clr = 0; vin = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 sample_en", sample_en, 1);
    chk("R1 flag", flag, 0);
    chk("R1 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    go(8'hA5, 1'b0, 2'd0); wait_idle();
    chk("R7 result A5", result, 8'hA5);
    chk("R8 flag set", flag, 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R8 flag cleared", flag, 0);

    go(8'h00, 1'b0, 2'd1); wait_idle();
    chk("R5 result 00", result, 8'h00);
    go(8'hFF, 1'b0, 2'd2); wait_idle();
    chk("R5 result FF", result, 8'hFF);
    go(8'h5A, 1'b0, 2'd3); wait_idle();
    chk("R4 result 5A", result, 8'h5A);
    go(8'h3C, 1'b1, 2'd0); wait_idle();
    chk("R3 RC result 3C", result, 8'h3C);

    // R6 timing: div 0 gives 1 + 9*2 clocks
    go(8'hC3, 1'b0, 2'd0);
    n = 0; while (busy) begin @(negedge clk); n++; end
    chk("R6 completion clocks", n, 19);

    // R9: a stray start while busy
    go(8'h81, 1'b0, 2'd0);
    repeat (5) @(negedge clk);
    clk_sel = 1'b1; div_sel = 2'd3; go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    n = 6; while (busy) begin @(negedge clk); n++; end
    chk("R9 timing unchanged", n, 19);
    chk("R9 result", result, 8'h81);
    clk_sel = 1'b0;

    // R11: divider change mid conversion
    go(8'h42, 1'b0, 2'd1);
    repeat (3) @(negedge clk);
    div_sel = 2'd3;
    n = 3; while (busy) begin @(negedge clk); n++; end
    chk("R11 captured divider", n, 73);
    chk("R11 result", result, 8'h42);

    // R10: abort mid conversion
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    old = result;
    go(8'h11, 1'b0, 2'd1);
    repeat (20) @(negedge clk);
    go_clr = 1'b1;
    @(negedge clk) go_clr = 1'b0;
    chk("R10 abort idle", busy, 0);
    chk("R10 abort result", result, old);
    chk("R10 abort flag", flag, 0);

    // R10: abort on the completion edge wins
    go(8'h77, 1'b0, 2'd0);
    wait_last_edge();
    go_clr = 1'b1;
    @(negedge clk) go_clr = 1'b0;
    chk("R10 late abort result", result, old);
    chk("R10 late abort flag", flag, 0);

    // R8: flag clear on the completion edge loses
    go(8'h99, 1'b1, 2'd0);
    wait_last_edge();
    flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R8 set beats clear", flag, 1);
    chk("R7 result 99", result, 8'h99);

    // R10: start with abort in the same cycle while idle
    @(negedge clk);
    go_set = 1'b1; go_clr = 1'b1;
    @(negedge clk);
    go_set = 1'b0; go_clr = 1'b0;
    chk("R10 no start", busy, 0);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule